// File: doc/BRIEF.md
# Sequential-Burst Memory Cycle Controller

This block connects a processor-style request bus to a page-mode memory with row and column strobes. On every clock the requester presents an active-low request, a sequential flag, a byte address, a width (word or halfword), a direction and a protection bit. The controller sorts the cycle into one of three kinds. A nonsequential cycle opens a fresh row and takes three clocks. A sequential cycle that lands in the still-open row with unchanged attributes takes one clock. An internal or idle cycle causes no memory activity and closes the row. While `bus_wait` is high, the requester must hold all of its inputs.

The state machine has four named states. ST_CLOSED means no row is open. ST_OPEN means a row is held open by the row strobe. ST_ROWSTB is the clock in which the row strobe falls. ST_COLN is the column clock that ends a nonsequential access. Both ST_CLOSED and ST_OPEN accept requests, and their transitions are as follows:
- A sequential hit moves ST_OPEN to ST_OPEN.
- A miss, or any nonsequential request, moves the accepting state to ST_ROWSTB.
- An internal or idle cycle moves the accepting state to ST_CLOSED.
- ST_ROWSTB always moves to ST_COLN.
- ST_COLN always moves to ST_OPEN.

Top module: `seqburst_memctl`

## Requirements
- R1: A cycle with `req_n` high, with `seq` either low (internal) or high (idle), drives `mem_ras_n` and `mem_cas_n` high, `bus_wait` low and `done` low in that clock.
- R2: A memory request that is not a sequential hit takes exactly three clocks. In clock 1 both strobes are high and `bus_wait` is high, with the row number on `mem_addr`. In clock 2 `mem_ras_n` is low, `mem_cas_n` is high and `bus_wait` is high. In clock 3 both strobes are low, `bus_wait` is low and `done` is high.
- R3: A request with `req_n` low and `seq` high is a sequential hit when the row is open, the address is in that row and width, direction and protection all match the burst. A hit completes in one clock with both strobes low, `bus_wait` low and `done` high.
- R4: An internal or idle cycle releases the row. The next sequential request is then served as the full three-clock access of R2.
- R5: A sequential request whose address row (address bits [11:6]) differs from the open row is served as the three-clock access of R2, and `proto_err` stays low.
- R6: A sequential request that changes width, direction or protection while a row is open raises `proto_err` in its first clock only, and is served as the three-clock access of R2. When no row is open, a sequential request never raises `proto_err`.
- R7: Rows and columns are taken from the address as follows:
  - Address bits [11:6] give the row, which is driven on `mem_addr` outside column clocks.
  - Address bits [5:2] give the column, which is driven in column clocks.
  - A word read returns the full 32-bit memory word on `rdata`.
  - A word write enables both halfword lanes (`mem_lane_we` = 2'b11).
- R8: A halfword read (`word_sz` = 0) returns `mem_rdata[31:16]` when address bit 1 is set and `mem_rdata[15:0]` otherwise, zero-extended to 32 bits.
- R9: A halfword write replicates `wdata[15:0]` into both halves of `mem_wdata` and enables only lane 1 (address bit 1 set) or lane 0. `rvalid` is high only in the completing clock of a read.
- R10: `bus_wait` is never high in a clock where `done` is high, and it stays high for both penalty clocks of every three-clock access.
- R11: After reset both strobes are high, `bus_wait`, `done` and `proto_err` are low and no row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Active-low memory request |
| seq | input | 1 | High: access continues the current burst |
| addr | input | AW | Byte address |
| word_sz | input | 1 | 1 = word, 0 = halfword |
| wr | input | 1 | 1 = write, 0 = read |
| prot | input | 1 | Protection attribute of the access |
| wdata | input | 32 | Write data (halfword in bits 15:0) |
| rdata | output | 32 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data valid this clock |
| done | output | 1 | Access completes this clock |
| bus_wait | output | 1 | Stall: requester holds its inputs |
| proto_err | output | 1 | Burst attribute changed on a sequential request |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_we | output | 2 | Halfword lane write enables |
| mem_addr | output | MAW | Multiplexed row / column address |
| mem_wdata | output | 32 | Data to memory |
| mem_rdata | input | 32 | Data from memory |

## Verification
The hardest conditions to reach are the ones where a sequential request meets a row that is no longer usable. This happens when an internal or idle cycle has closed the row, when the burst walks across a 64-byte row edge, or when an attribute flips in the middle of a burst. Directed cases aim at each of these: a word burst starting at 0x38, an internal cycle and an idle cycle placed between beats, and flips of direction and of width. Random bursts of random length then insert internal cycles and attribute flips between beats, and their addresses wrap across row edges. A bench model tracks open row and burst attributes to predict the latency and the error flag of each cycle. A shadow memory checks every value read back.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        ST_CLOSED,
        ST_OPEN,
        ST_ROWSTB,
        ST_COLN
    } sb_state_e;

    typedef enum logic [1:0] {
        CY_NSEQ,
        CY_SEQ,
        CY_INTERNAL,
        CY_IDLE
    } sb_cycle_e;

    typedef struct packed {
        logic word;
        logic wr;
        logic prot;
    } sb_attr_t;
endpackage

// File: rtl/sb_cycle_decode.sv
module sb_cycle_decode
    import sb_pkg::*;
(
    input  logic      req_n,
    input  logic      seq,
    output sb_cycle_e cyc
);
    always_comb begin
        unique case ({req_n, seq})
            2'b00:   cyc = CY_NSEQ;
            2'b01:   cyc = CY_SEQ;
            2'b10:   cyc = CY_INTERNAL;
            default: cyc = CY_IDLE;
        endcase
    end
endmodule

// File: rtl/sb_burst_track.sv
module sb_burst_track
    import sb_pkg::*;
#(
    parameter int ROWW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [ROWW-1:0] cur_row,
    input  sb_attr_t        cur_attr,
    output logic            row_hit,
    output logic            attr_hit
);
    logic [ROWW-1:0] open_row;
    sb_attr_t        open_attr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_row  <= '0;
            open_attr <= '0;
        end else if (load) begin
            open_row  <= cur_row;
            open_attr <= cur_attr;
        end
    end

    assign row_hit  = (cur_row == open_row);
    assign attr_hit = (cur_attr == open_attr);
endmodule

// File: rtl/sb_strobe_fsm.sv
module sb_strobe_fsm
    import sb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sb_cycle_e cyc,
    input  logic      row_hit,
    input  logic      attr_hit,
    output logic      ras_n,
    output logic      cas_n,
    output logic      wait_o,
    output logic      xfer,
    output logic      use_col,
    output logic      load,
    output logic      proto_err,
    output logic      accepting
);
    sb_state_e state, nxt;
    logic      mem_req;
    logic      seq_hit;

    assign mem_req   = (cyc == CY_NSEQ) || (cyc == CY_SEQ);
    assign accepting = (state == ST_CLOSED) || (state == ST_OPEN);
    assign seq_hit   = (state == ST_OPEN) && (cyc == CY_SEQ) && row_hit && attr_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CLOSED;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_CLOSED, ST_OPEN: begin
                if (!mem_req)     nxt = ST_CLOSED;
                else if (seq_hit) nxt = ST_OPEN;
                else              nxt = ST_ROWSTB;
            end
            ST_ROWSTB: nxt = ST_COLN;
            ST_COLN:   nxt = ST_OPEN;
            default:   nxt = ST_CLOSED;
        endcase
    end

    always_comb begin
        ras_n     = 1'b1;
        cas_n     = 1'b1;
        wait_o    = 1'b0;
        xfer      = 1'b0;
        use_col   = 1'b0;
        load      = 1'b0;
        proto_err = 1'b0;
        unique case (state)
            ST_CLOSED, ST_OPEN: begin
                if (mem_req && seq_hit) begin
                    ras_n   = 1'b0;
                    cas_n   = 1'b0;
                    use_col = 1'b1;
                    xfer    = 1'b1;
                end else if (mem_req) begin
                    // row address phase: row released, new row on the bus
                    wait_o    = 1'b1;
                    load      = 1'b1;
                    proto_err = (state == ST_OPEN) && (cyc == CY_SEQ) && !attr_hit;
                end
            end
            ST_ROWSTB: begin
                ras_n  = 1'b0;
                wait_o = 1'b1;
            end
            ST_COLN: begin
                ras_n   = 1'b0;
                cas_n   = 1'b0;
                use_col = 1'b1;
                xfer    = 1'b1;
            end
            default: ;
        endcase
    end

    // R1: internal and idle cycles leave memory untouched
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accepting && !mem_req) |-> (ras_n && cas_n && !wait_o && !xfer));

    // R2: row phase is followed by the row strobe, then by the column strobe
    p_row_then_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_o && ras_n) |=> (wait_o && !ras_n && cas_n));
    p_strobe_then_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_o && !ras_n) |=> (!wait_o && !cas_n && xfer));

    // R3: the column strobe only pulses under an asserted row strobe
    p_cas_under_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R4: an internal or idle cycle while open closes the row
    p_release_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && !mem_req) |=> (state == ST_CLOSED));

    // R10: completion never coincides with a stall
    p_done_no_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> !wait_o);
endmodule

// File: rtl/seqburst_memctl.sv
module seqburst_memctl
    import sb_pkg::*;
#(
    parameter int AW   = 12,
    parameter int COLW = 4,
    parameter int DW   = 32,
    localparam int ROWW = AW - 2 - COLW,
    localparam int MAW  = (ROWW > COLW) ? ROWW : COLW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_n,
    input  logic           seq,
    input  logic [AW-1:0]  addr,
    input  logic           word_sz,
    input  logic           wr,
    input  logic           prot,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic           rvalid,
    output logic           done,
    output logic           bus_wait,
    output logic           proto_err,
    output logic           mem_ras_n,
    output logic           mem_cas_n,
    output logic           mem_we_n,
    output logic [1:0]     mem_lane_we,
    output logic [MAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata
);
    localparam int HW = DW / 2;

    sb_cycle_e       cyc;
    sb_attr_t        cur_attr;
    logic [ROWW-1:0] cur_row;
    logic [COLW-1:0] cur_col;
    logic            row_hit, attr_hit;
    logic            use_col, load, accepting;
    logic            xfer;
    logic [HW-1:0]   half_sel;

    assign cur_row  = addr[AW-1 -: ROWW];
    assign cur_col  = addr[COLW+1:2];
    assign cur_attr = '{word: word_sz, wr: wr, prot: prot};

    sb_cycle_decode u_decode (
        .req_n (req_n),
        .seq   (seq),
        .cyc   (cyc)
    );

    sb_burst_track #(.ROWW(ROWW)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cur_row  (cur_row),
        .cur_attr (cur_attr),
        .row_hit  (row_hit),
        .attr_hit (attr_hit)
    );

    sb_strobe_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc       (cyc),
        .row_hit   (row_hit),
        .attr_hit  (attr_hit),
        .ras_n     (mem_ras_n),
        .cas_n     (mem_cas_n),
        .wait_o    (bus_wait),
        .xfer      (xfer),
        .use_col   (use_col),
        .load      (load),
        .proto_err (proto_err),
        .accepting (accepting)
    );

    assign done     = xfer;
    assign mem_addr = use_col ? MAW'(cur_col) : MAW'(cur_row);
    assign mem_we_n = !(xfer && wr);

    always_comb begin
        mem_lane_we = 2'b00;
        if (xfer && wr) begin
            if (word_sz)      mem_lane_we = 2'b11;
            else if (addr[1]) mem_lane_we = 2'b10;
            else              mem_lane_we = 2'b01;
        end
    end

    assign mem_wdata = word_sz ? wdata : {2{wdata[HW-1:0]}};
    assign half_sel  = addr[1] ? mem_rdata[DW-1:HW] : mem_rdata[HW-1:0];
    assign rvalid    = xfer && !wr;

    always_comb begin
        rdata = '0;
        if (rvalid) rdata = word_sz ? mem_rdata : {{HW{1'b0}}, half_sel};
    end

    // R5: a sequential request outside the open row pays the row penalty
    p_cross_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accepting && !req_n && seq && !row_hit) |-> bus_wait);

    // R6: an attribute violation is reported only on a stalled sequential request
    p_err_penalty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (bus_wait && !req_n && seq));

    // R9: read data valid only on completing reads
    p_rvalid_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (done && !wr && mem_we_n));

    // R7: memory is written only under the column strobe
    p_we_with_cas_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cas_n && (mem_lane_we != 2'b00)));
endmodule

// File: tb/seqburst_memctl_tb.sv
module seqburst_memctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 12;
    localparam int COLW = 4;
    localparam int ROWW = AW - 2 - COLW;
    localparam int MAW  = (ROWW > COLW) ? ROWW : COLW;
    localparam int NW   = 1 << (AW - 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_n = 1'b1;
    logic          seq = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          word_sz = 1'b1;
    logic          wr = 1'b0;
    logic          prot = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rvalid, done, bus_wait, proto_err;
    logic          mem_ras_n, mem_cas_n, mem_we_n;
    logic [1:0]    mem_lane_we;
    logic [MAW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqburst_memctl #(.AW(AW), .COLW(COLW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .seq(seq), .addr(addr),
        .word_sz(word_sz), .wr(wr), .prot(prot), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .done(done), .bus_wait(bus_wait),
        .proto_err(proto_err), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_lane_we(mem_lane_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // page-mode memory: row latched on the falling row strobe
    logic [31:0]     bm [NW];
    logic [31:0]     ref_mem [NW];
    logic [ROWW-1:0] bm_row = '0;
    logic            prev_ras_n = 1'b1;

    assign mem_rdata = bm[{bm_row, mem_addr[COLW-1:0]}];

    always @(posedge clk) begin
        if (prev_ras_n && !mem_ras_n) bm_row <= mem_addr[ROWW-1:0];
        prev_ras_n <= mem_ras_n;
        if (!mem_cas_n && !mem_we_n) begin
            if (mem_lane_we[0]) bm[{bm_row, mem_addr[COLW-1:0]}][15:0]  <= mem_wdata[15:0];
            if (mem_lane_we[1]) bm[{bm_row, mem_addr[COLW-1:0]}][31:16] <= mem_wdata[31:16];
        end
    end

    int n_cmp = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    logic            m_open = 1'b0;
    logic [ROWW-1:0] m_row = '0;
    logic [2:0]      m_attr = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a, input logic w);
        logic [31:0] d;
        d = ref_mem[a[AW-1:2]];
        if (w) return d;
        return a[1] ? {16'h0, d[31:16]} : {16'h0, d[15:0]};
    endfunction

    task automatic run_req(input logic rq_n, input logic sq, input logic [AW-1:0] a,
                           input logic w, input logic wrt, input logic pr,
                           input logic [31:0] wd, input string ctx);
        logic [2:0] at;
        logic       hit, eerr;
        at   = {w, wrt, pr};
        hit  = m_open && !rq_n && sq && (a[AW-1 -: ROWW] == m_row) && (at == m_attr);
        eerr = m_open && !rq_n && sq && (at != m_attr);
        req_n = rq_n; seq = sq; addr = a; word_sz = w; wr = wrt; prot = pr; wdata = wd;
        #1;
        chk(proto_err == eerr, {ctx, " R6 error flag"}, 32'(proto_err), 32'(eerr));
        if (rq_n) begin
            chk(mem_ras_n && mem_cas_n && !bus_wait && !done, {ctx, " R1 quiet cycle"},
                {28'h0, mem_ras_n, mem_cas_n, bus_wait, done}, 32'hC);
            m_open = 1'b0;
        end else begin
            if (!hit) begin
                chk(mem_ras_n && mem_cas_n && bus_wait && mem_addr == MAW'(a[AW-1 -: ROWW]),
                    {ctx, " R2 row phase"}, {27'h0, mem_ras_n, mem_cas_n, bus_wait, 2'b0}, 32'h1C);
                @(negedge clk); #1;
                chk(!mem_ras_n && mem_cas_n && bus_wait && !done, {ctx, " R10 R2 strobe phase"},
                    {28'h0, mem_ras_n, mem_cas_n, bus_wait, done}, 32'h6);
                @(negedge clk); #1;
            end
            chk(!mem_ras_n && !mem_cas_n && !bus_wait && done && mem_addr == MAW'(a[COLW+1:2]),
                {ctx, hit ? " R3 column" : " R2 column"},
                {28'h0, mem_ras_n, mem_cas_n, bus_wait, done}, 32'h1);
            if (wrt) begin
                chk(!rvalid && mem_lane_we == (w ? 2'b11 : (a[1] ? 2'b10 : 2'b01)),
                    {ctx, " R9 write lanes"}, {29'h0, rvalid, mem_lane_we},
                    {30'h0, w ? 2'b11 : (a[1] ? 2'b10 : 2'b01)});
                if (w) ref_mem[a[AW-1:2]] = wd;
                else if (a[1]) ref_mem[a[AW-1:2]][31:16] = wd[15:0];
                else ref_mem[a[AW-1:2]][15:0] = wd[15:0];
            end else begin
                chk(rvalid && rdata == exp_read(a, w), {ctx, w ? " R7 word read" : " R8 halfword read"},
                    rdata, exp_read(a, w));
            end
            m_open = 1'b1;
            m_row  = a[AW-1 -: ROWW];
            m_attr = at;
        end
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unused;
        logic [AW-1:0] a;
        logic w, wrt, pr;
        for (int i = 0; i < NW; i++) begin
            bm[i]      = 32'(i) * 32'h9E3779B1 + 32'h1357;
            ref_mem[i] = 32'(i) * 32'h9E3779B1 + 32'h1357;
        end
        unused = $urandom(32'd7331);
        repeat (3) @(negedge clk);
        #1;
        // R11: reset state
        chk(mem_ras_n && mem_cas_n && !bus_wait && !done && !proto_err, "R11 reset outputs",
            {27'h0, mem_ras_n, mem_cas_n, bus_wait, done, proto_err}, 32'h18);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: sequential first request after reset is a full access without error
        run_req(0, 1, 12'h080, 1, 0, 0, 0, "R11");
        // word burst across the 64-byte row edge (R5)
        run_req(0, 0, 12'h038, 1, 0, 0, 0, "R7");
        run_req(0, 1, 12'h03C, 1, 0, 0, 0, "R3");
        run_req(0, 1, 12'h040, 1, 0, 0, 0, "R5");
        run_req(0, 1, 12'h044, 1, 0, 0, 0, "R3");
        // word write burst, read back
        run_req(0, 0, 12'h200, 1, 1, 0, 32'hCAFE0001, "R7");
        run_req(0, 1, 12'h204, 1, 1, 0, 32'hCAFE0002, "R7");
        run_req(0, 0, 12'h200, 1, 0, 0, 0, "R7");
        run_req(0, 1, 12'h204, 1, 0, 0, 0, "R7");
        // halfword read burst, both lanes
        run_req(0, 0, 12'h100, 0, 0, 0, 0, "R8");
        run_req(0, 1, 12'h102, 0, 0, 0, 0, "R8");
        run_req(0, 1, 12'h104, 0, 0, 0, 0, "R8");
        // internal and idle cycles between beats (R4, R1)
        run_req(1, 0, 12'h106, 0, 0, 0, 0, "R1");
        run_req(0, 1, 12'h106, 0, 0, 0, 0, "R4");
        run_req(1, 1, 12'h108, 0, 0, 0, 0, "R1");
        run_req(0, 1, 12'h108, 0, 0, 0, 0, "R4");
        // protocol errors: direction flip, width flip, protection flip (R6)
        run_req(0, 1, 12'h10A, 0, 1, 0, 32'h0000BEEF, "R6");
        run_req(0, 1, 12'h10C, 1, 1, 0, 32'h12345678, "R6");
        run_req(0, 1, 12'h110, 1, 1, 1, 32'h9ABCDEF0, "R6");
        // halfword writes on both lanes, word read back (R9)
        run_req(0, 0, 12'h300, 0, 1, 0, 32'h0000A5A5, "R9");
        run_req(0, 1, 12'h302, 0, 1, 0, 32'h00005A5A, "R9");
        run_req(0, 0, 12'h300, 1, 0, 0, 0, "R9");
        // address wrap at top of space
        run_req(0, 0, 12'hFFC, 1, 0, 0, 0, "R7");
        run_req(0, 1, 12'h000, 1, 0, 0, 0, "R5");
        // random bursts
        for (int b = 0; b < 400; b++) begin
            w   = 1'($urandom % 2);
            wrt = 1'($urandom % 2);
            pr  = 1'($urandom % 2);
            a   = AW'($urandom) & (w ? 12'hFFC : 12'hFFE);
            run_req(0, 0, a, w, wrt, pr, $urandom, "R2");
            for (int k = 0; k < int'($urandom % 6); k++) begin
                a = a + (w ? 12'd4 : 12'd2);
                if ($urandom % 8 == 0) run_req(1, 1'($urandom % 2), a, w, wrt, pr, 0, "R1");
                if ($urandom % 10 == 0) wrt = !wrt;
                if ($urandom % 12 == 0) pr = !pr;
                run_req(0, 1, a, w, wrt, pr, $urandom, "R3");
            end
            if ($urandom % 4 == 0) run_req(1, 0, a, w, wrt, pr, 0, "R1");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule